// File: doc/BRIEF.md
# Byte-Wide Grid Static Memory

This block is a 256-byte static memory. Each of its eight bit planes is a square grid of 16 by 16 one-bit storage cells. The byte address is cut into a row field and a column field. Each field drives its own decoder, which turns it into a one-hot set of select lines. A cell takes part in an access only where its row line and its column line are both high. All eight planes share the same select lines, so one address reaches the same cell position in every plane and the memory handles whole bytes.

A single direction control chooses between storing and fetching, and a chip enable opens or closes the data port. The port has a separate input bus, an output bus and an output-valid flag in place of a shared bidirectional line. The gating rules match those of a shared line: the enable must be high for data to move in either direction, and the memory drives output only on a fetch. Stores take effect on the rising clock edge. Fetches are combinational and show the addressed byte in the same cycle. Contents after power-up are unspecified.

The access mode is a small enumerated type worked out each cycle from the enable and direction inputs: `MODE_OFF`, `MODE_FETCH` or `MODE_STORE`. The block holds no sequencing state, so there are no transitions between modes. Each cycle's mode depends only on that cycle's inputs.

Top module: `sram_grid`

## Requirements
- R1: A byte stored at an address with `ce`=1, `we`=1 is returned on `rdata` by a later fetch (`ce`=1, `we`=0) from the same address, provided no store to that address comes in between.
- R2: Address bits [7:4] select the grid row and bits [3:0] select the grid column. A store to one address leaves the contents of every other address unchanged.
- R3: Exactly one cell per bit plane is selected for any address. A store changes neither the other cells in the same row nor the other cells in the same column.
- R4: When `ce`=0, a store request (`we`=1) is ignored and the addressed byte keeps its earlier value.
- R5: When `ce`=0, `oe` is 0 and `rdata` is 0 whatever the other inputs are.
- R6: When `ce`=1 and `we`=1, `oe` is 0 and `rdata` is 0.
- R7: A fetch is combinational. With `ce`=1 and `we`=0, `oe` is 1 and `rdata` follows a change of `addr` within the same cycle, with no clock edge needed.
- R8: A store is captured on the rising edge of `clk`. Before that edge a fetch of the address returns the old byte; after it, a fetch returns the new byte.
- R9: Each of the eight data bits is stored independently, so any bit pattern (walking one, walking zero, alternating) reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; stores are captured on its rising edge |
| ce | input | 1 | Chip enable; 0 isolates the data port in both directions |
| we | input | 1 | Direction control: 1 store, 0 fetch |
| addr | input | 8 | Byte address: bits [7:4] row, bits [3:0] column |
| wdata | input | 8 | Byte to store |
| rdata | output | 8 | Fetched byte; 0 when `oe` is 0 |
| oe | output | 1 | High when `rdata` carries a fetched byte |

## Verification
The bench writes to a cell and then reads back its row-mates and column-mates. A decoder that leaves more than one line high, or a cell select that uses OR in place of AND, would smear a store across the whole row or column. Store requests made with the enable low must leave the memory unchanged and keep the port silent. A design that lets them through would corrupt the reference copy, and one that drives `oe` on a store would show data during writes. Two reads are made back to back within one clock phase at different addresses, which catches a fetch path that was registered by mistake. A read just before the write edge and another just after it catch a store that lands a cycle late, or one that is applied before the edge.

// File: rtl/sram_grid_pkg.sv
package sram_grid_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_FETCH = 2'd1,
        MODE_STORE = 2'd2
    } access_mode_t;

endpackage

// File: rtl/sram_grid_decoder.sv
module sram_grid_decoder #(
    parameter int CODE_BITS = 4
) (
    input  logic [CODE_BITS-1:0]      code_i,
    output logic [(1<<CODE_BITS)-1:0] line_o
);
    localparam int LINES = 1 << CODE_BITS;

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            line_o[i] = (code_i == CODE_BITS'(i));
        end
    end

    // a known code must raise exactly one select line
    always_comb begin
        if (!$isunknown(code_i)) begin
            assert_line_onehot_R3: assert ($countones(line_o) == 1)
                else $error("decoder raised %0d lines", $countones(line_o));
        end
    end

endmodule

// File: rtl/sram_grid_slice.sv
module sram_grid_slice #(
    parameter int ROWS = 16,
    parameter int COLS = 16
) (
    input  logic            clk,
    input  logic            store_i,
    input  logic [ROWS-1:0] row_i,
    input  logic [COLS-1:0] col_i,
    input  logic            bit_i,
    output logic            bit_o
);
    logic [ROWS-1:0][COLS-1:0] cell_q;
    logic [ROWS-1:0][COLS-1:0] pick;

    // cell selection: row line AND column line
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                pick[r][c] = row_i[r] & col_i[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (store_i && pick[r][c]) begin
                    cell_q[r][c] <= bit_i;
                end
            end
        end
    end

    assign bit_o = |(cell_q & pick);

    // the grid crossing must isolate a single cell
    always_comb begin
        if (!$isunknown({row_i, col_i}) && row_i != '0 && col_i != '0) begin
            assert_single_cell_R3: assert ($countones(pick) == 1)
                else $error("%0d cells picked", $countones(pick));
        end
    end

endmodule

// File: rtl/sram_grid.sv
module sram_grid
    import sram_grid_pkg::*;
#(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4,
    parameter int WIDTH    = 8
) (
    input  logic                         clk,
    input  logic                         ce,
    input  logic                         we,
    input  logic [ROW_BITS+COL_BITS-1:0] addr,
    input  logic [WIDTH-1:0]             wdata,
    output logic [WIDTH-1:0]             rdata,
    output logic                         oe
);
    localparam int ADDR_BITS = ROW_BITS + COL_BITS;
    localparam int ROWS      = 1 << ROW_BITS;
    localparam int COLS      = 1 << COL_BITS;

    access_mode_t    mode;
    logic            store_en;
    logic            fetch_en;
    logic [ROWS-1:0] row_line;
    logic [COLS-1:0] col_line;
    logic [WIDTH-1:0] plane_bits;

    always_comb begin
        unique case ({ce, we})
            2'b10:   mode = MODE_FETCH;
            2'b11:   mode = MODE_STORE;
            default: mode = MODE_OFF;
        endcase
    end

    always_comb begin
        store_en = 1'b0;
        fetch_en = 1'b0;
        unique case (mode)
            MODE_FETCH: fetch_en = 1'b1;
            MODE_STORE: store_en = 1'b1;
            default:    ;
        endcase
    end

    sram_grid_decoder #(.CODE_BITS(ROW_BITS)) u_row_dec (
        .code_i (addr[ADDR_BITS-1:COL_BITS]),
        .line_o (row_line)
    );

    sram_grid_decoder #(.CODE_BITS(COL_BITS)) u_col_dec (
        .code_i (addr[COL_BITS-1:0]),
        .line_o (col_line)
    );

    for (genvar b = 0; b < WIDTH; b++) begin : g_plane
        sram_grid_slice #(.ROWS(ROWS), .COLS(COLS)) u_plane (
            .clk     (clk),
            .store_i (store_en),
            .row_i   (row_line),
            .col_i   (col_line),
            .bit_i   (wdata[b]),
            .bit_o   (plane_bits[b])
        );
    end

    assign oe    = fetch_en;
    assign rdata = fetch_en ? plane_bits : '0;

    // port isolation checks against the raw pins
    always_comb begin
        if (!$isunknown({ce, we})) begin
            assert_port_shut_R5: assert (ce || (!oe && rdata == '0))
                else $error("port active with chip disabled");
            assert_no_drive_on_store_R6: assert (!(ce && we) || !oe)
                else $error("output enabled during store");
            assert_drive_on_fetch_R7: assert (!(ce && !we) || oe)
                else $error("fetch without output enable");
        end
    end

endmodule

// File: tb/sram_grid_test.sv
module sram_grid_test;

    logic       clk = 1'b0;
    logic       ce = 1'b0;
    logic       we = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       oe;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [7:0] mirror [256];

    always #2 clk = ~clk;

    sram_grid uut (
        .clk(clk), .ce(ce), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .oe(oe)
    );

    // expected port value {oe, rdata} from the requirements
    function automatic logic [8:0] expect_port(logic e, logic w, logic [7:0] stored);
        if (e && !w) return {1'b1, stored};
        return 9'h000;
    endfunction

    task automatic check(string req, logic [8:0] got, logic [8:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got oe/data=%h expected %h", req, got, exp);
        end
    endtask

    task automatic store(logic [7:0] a, logic [7:0] d, string req);
        @(negedge clk);
        ce = 1; we = 1; addr = a; wdata = d;
        #1 check(req, {oe, rdata}, expect_port(1, 1, 8'h00));
        @(posedge clk);
        mirror[a] = d;
    endtask

    task automatic fetch(logic [7:0] a, string req);
        @(negedge clk);
        ce = 1; we = 0; addr = a; wdata = $urandom;
        #1 check(req, {oe, rdata}, expect_port(1, 0, mirror[a]));
    endtask

    task automatic blocked(logic [7:0] a, logic w);
        @(negedge clk);
        ce = 0; we = w; addr = a; wdata = $urandom;
        #1 check("R5", {oe, rdata}, expect_port(0, w, mirror[a]));
        @(posedge clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R5 at start: disabled port is silent
        #1 check("R5", {oe, rdata}, 9'h000);

        for (int a = 0; a < 256; a++) store(8'(a), 8'($urandom), "R6");
        for (int a = 0; a < 256; a++) fetch(8'(a), "R1");

        // R3: neighbours in row 5 and column 5 of cell 0x55
        for (int k = 0; k < 16; k++) begin
            store(8'(8'h50 + k), 8'h00, "R6");
            store(8'(k * 16 + 5), 8'h00, "R6");
        end
        store(8'h55, 8'hFF, "R6");
        for (int k = 0; k < 16; k++) begin
            fetch(8'(8'h50 + k), "R3");
            fetch(8'(k * 16 + 5), "R3");
        end

        // R2: row/column field order, 0x12 vs 0x21
        store(8'h12, 8'hA1, "R6");
        store(8'h21, 8'h5E, "R6");
        fetch(8'h12, "R2");
        fetch(8'h21, "R2");

        // R4: disabled stores leave contents alone
        for (int k = 0; k < 8; k++) begin
            blocked(8'h12, 1'b1);
            fetch(8'h12, "R4");
        end

        // R7: two addresses in one low phase without a clock edge
        @(negedge clk);
        ce = 1; we = 0; addr = 8'h12;
        #0.5 check("R7", {oe, rdata}, {1'b1, mirror[8'h12]});
        addr = 8'h21;
        #0.5 check("R7", {oe, rdata}, {1'b1, mirror[8'h21]});

        // R8: old value before edge, new value after
        fetch(8'h33, "R8");
        store(8'h33, ~mirror[8'h33], "R8");
        fetch(8'h33, "R8");

        // R9: bit patterns per plane
        for (int b = 0; b < 8; b++) begin
            store(8'hC7, 8'(1 << b), "R6");
            fetch(8'hC7, "R9");
            store(8'hC7, ~8'(1 << b), "R6");
            fetch(8'hC7, "R9");
        end
        store(8'hC7, 8'hAA, "R6"); fetch(8'hC7, "R9");
        store(8'hC7, 8'h55, "R6"); fetch(8'hC7, "R9");

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            a = 8'($urandom);
            case ($urandom % 4)
                0: store(a, 8'($urandom), "R6");
                1: fetch(a, "R1");
                2: blocked(a, 1'b1);
                default: blocked(a, 1'b0);
            endcase
        end
        for (int a = 0; a < 256; a++) fetch(8'(a), "R2");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule